// File: doc/BRIEF.md
# Single-Step Shift Register Unit

This block holds an n-bit word and moves it one position per enabled cycle. It has eight shift kinds: zero-fill, rotate, sign-aware arithmetic and serial-fill, each to the left and to the right. A parallel load puts a whole word into the register. The bit that leaves the word on each shift is kept in a carry flag. A sign-reversal flag reports an arithmetic left shift whose result no longer has the sign of the operand.

Bits are numbered 0 (least significant, rightmost) to W-1 (the sign). A left shift moves bit i to bit i+1, and a right shift moves bit i to bit i-1. The block has two serial inputs, one for each direction. The left-direction input enters at bit 0 and the right-direction input enters at bit W-1. They are used only by the two serial-fill shift kinds. Multi-position shifting in a single cycle is not provided.

Top module: `sreg_shifter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `q`, `carry_out` and `ovf` are all zero.
- R2: When `load` is high, `q` takes `load_data` on the next edge and `ovf` clears, whatever `shift_en` and `op` are; `carry_out` is kept.
- R3: With `load` and `shift_en` both low, `q`, `carry_out` and `ovf` keep their values.
- R4: `op`=0 shifts left and puts 0 into bit 0; `op`=1 shifts right and puts 0 into bit W-1.
- R5: `op`=2 rotates left, so old bit W-1 moves to bit 0; `op`=3 rotates right, so old bit 0 moves to bit W-1.
- R6: `op`=5 shifts right arithmetically: bit W-1 stays unchanged and also feeds bit W-2.
- R7: `op`=4 shifts left arithmetically and puts 0 into bit 0. `ovf` is set exactly when the new bit W-1 differs from the old bit W-1.
- R8: Any enabled shift with an `op` other than 4 clears `ovf`.
- R9: `op`=6 shifts left with `ser_lsb_in` entering bit 0; `op`=7 shifts right with `ser_msb_in` entering bit W-1.
- R10: On every enabled shift, `carry_out` takes the bit that left the word. That is old bit W-1 for ops 0, 2, 4 and 6, and old bit 0 for ops 1, 3, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Parallel load strobe; takes priority over shifting |
| load_data | input | W | Word to load |
| op | input | 3 | Shift kind, encoded as 0 to 7 per R4 to R9 |
| shift_en | input | 1 | Performs one shift of kind `op` |
| ser_lsb_in | input | 1 | Fill bit for serial left shift |
| ser_msb_in | input | 1 | Fill bit for serial right shift |
| q | output | W | Register contents |
| carry_out | output | 1 | Bit that left the word on the last shift |
| ovf | output | 1 | Sign reversal on the last arithmetic left shift |

## Verification
The assertions check the following on every cycle:
- load priority and load capture;
- holding when idle;
- the rotate-right mapping;
- sign retention on arithmetic right shift;
- the overflow rule on arithmetic left shift, and overflow clearing by other shifts;
- which end feeds the carry on left shifts.

The bench's behavioural model covers what these properties leave open:
- the exact fill bit of every shift kind, including the serial inputs;
- the carry on right shifts;
- mixed sequences in which loads and shifts of all kinds interleave.

Directed cases cover overflow on both sign reversals, multi-step rotation back to the start, and repeated arithmetic right shifts of a negative word.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  // Shift kinds; the numeric codes are part of the block's interface.
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ROL = 3'd2,
    OP_ROR = 3'd3,
    OP_ASL = 3'd4,
    OP_ASR = 3'd5,
    OP_SSL = 3'd6,
    OP_SSR = 3'd7
  } shift_op_e;

  // Left-moving kinds send bit W-1 out to the carry.
  function automatic logic moves_left(shift_op_e k);
    return (k == OP_LSL) || (k == OP_ROL) || (k == OP_ASL) || (k == OP_SSL);
  endfunction

endpackage

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  shift_op_e    kind,
  input  logic         ser_lsb,
  input  logic         ser_msb,
  output logic [W-1:0] nxt,
  output logic         exit_bit,
  output logic         sign_flip
);

  logic left;
  logic fill_lsb;
  logic fill_msb;

  assign left = moves_left(kind);

  // Bit entering position 0 on a left move.
  always_comb begin
    unique case (kind)
      OP_ROL:  fill_lsb = cur[W-1];
      OP_SSL:  fill_lsb = ser_lsb;
      default: fill_lsb = 1'b0;
    endcase
  end

  // Bit entering position W-1 on a right move.
  always_comb begin
    unique case (kind)
      OP_ROR:  fill_msb = cur[0];
      OP_ASR:  fill_msb = cur[W-1];
      OP_SSR:  fill_msb = ser_msb;
      default: fill_msb = 1'b0;
    endcase
  end

  assign nxt       = left ? {cur[W-2:0], fill_lsb} : {fill_msb, cur[W-1:1]};
  assign exit_bit  = left ? cur[W-1] : cur[0];
  assign sign_flip = (kind == OP_ASL) && (cur[W-1] != cur[W-2]);

endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl (
  input  logic rst_n,
  input  logic load,
  input  logic shift_en,
  output logic load_fire,
  output logic shift_fire
);

  // Load wins over shift; nothing fires while reset is held.
  assign load_fire  = rst_n && load;
  assign shift_fire = rst_n && !load && shift_en;

endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
  import shifter_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic [2:0]   op,
  input  logic         shift_en,
  input  logic         ser_lsb_in,
  input  logic         ser_msb_in,
  output logic [W-1:0] q,
  output logic         carry_out,
  output logic         ovf
);

  if (W < 2) begin : g_bad_width
    initial $error("sreg_shifter needs W >= 2");
  end

  shift_op_e    kind;
  logic [W-1:0] shifted;
  logic         exit_bit;
  logic         sign_flip;
  logic         load_fire;
  logic         shift_fire;

  assign kind = shift_op_e'(op);

  shift_ctrl u_ctrl (
    .rst_n      (rst_n),
    .load       (load),
    .shift_en   (shift_en),
    .load_fire  (load_fire),
    .shift_fire (shift_fire)
  );

  shift_datapath #(.W(W)) u_dp (
    .cur       (q),
    .kind      (kind),
    .ser_lsb   (ser_lsb_in),
    .ser_msb   (ser_msb_in),
    .nxt       (shifted),
    .exit_bit  (exit_bit),
    .sign_flip (sign_flip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q         <= '0;
      carry_out <= 1'b0;
      ovf       <= 1'b0;
    end else if (load_fire) begin
      q   <= load_data;
      ovf <= 1'b0;
    end else if (shift_fire) begin
      q         <= shifted;
      carry_out <= exit_bit;
      ovf       <= sign_flip;
    end
  end

endmodule

// File: rtl/shifter_checker.sv
module shifter_checker
  import shifter_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic [W-1:0] load_data,
  input logic [2:0]   op,
  input logic         shift_en,
  input logic [W-1:0] q,
  input logic         carry_out,
  input logic         ovf,
  input logic         shift_fire
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_data)) && !ovf);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> $stable(q) && $stable(carry_out) && $stable(ovf));

  p_ror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && op == OP_ROR) |=> q == {$past(q[0]), $past(q[W-1:1])});

  p_sign_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && op == OP_ASR) |=> q[W-1] == $past(q[W-1]));

  p_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && op == OP_ASL) |=> (ovf == (q[W-1] != $past(q[W-1]))) && !q[0]);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && op != OP_ASL) |=> !ovf);

  p_carry_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && moves_left(shift_op_e'(op))) |=> carry_out == $past(q[W-1]));

endmodule

bind sreg_shifter shifter_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .load_data  (load_data),
  .op         (op),
  .shift_en   (shift_en),
  .q          (q),
  .carry_out  (carry_out),
  .ovf        (ovf),
  .shift_fire (shift_fire)
);

// File: tb/test_sreg_shifter.sv
module test_sreg_shifter;

  localparam int W    = 8;
  localparam int MOD  = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] load_data = '0;
  logic [2:0]   op = 3'd0;
  logic         shift_en = 1'b0;
  logic         ser_lsb_in = 1'b0;
  logic         ser_msb_in = 1'b0;
  logic [W-1:0] q;
  logic         carry_out;
  logic         ovf;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference state
  int mq = 0;
  int mc = 0;
  int mo = 0;

  always #10 clk = ~clk;

  sreg_shifter #(.W(W)) i_sreg_shifter (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data), .op(op),
    .shift_en(shift_en), .ser_lsb_in(ser_lsb_in), .ser_msb_in(ser_msb_in),
    .q(q), .carry_out(carry_out), .ovf(ovf)
  );

  task automatic compare(input string tag);
    checks++;
    if (int'(q) != mq || int'(carry_out) != mc || int'(ovf) != mo) begin
      failures++;
      $display("FAIL %s: actual q=%0d c=%0d v=%0d expected q=%0d c=%0d v=%0d",
               tag, q, carry_out, ovf, mq, mc, mo);
    end
  endtask

  // Behavioural model of one clock, then compare at the following falling edge.
  task automatic step(input bit ld, input int d, input int k, input bit en,
                      input bit sl, input bit sr, input string tag);
    int old;
    bit top;
    load = ld; load_data = W'(d); op = 3'(k); shift_en = en;
    ser_lsb_in = sl; ser_msb_in = sr;
    old = mq;
    top = (old >= HALF);
    if (ld) begin
      mq = d % MOD; mo = 0;
    end else if (en) begin
      case (k)
        0: begin mc = top; mq = (old * 2) % MOD; end
        1: begin mc = old % 2; mq = old / 2; end
        2: begin mc = top; mq = (old * 2) % MOD + (top ? 1 : 0); end
        3: begin mc = old % 2; mq = old / 2 + ((old % 2) ? HALF : 0); end
        4: begin mc = top; mq = (old * 2) % MOD; end
        5: begin mc = old % 2; mq = old / 2 + (top ? HALF : 0); end
        6: begin mc = top; mq = (old * 2) % MOD + sl; end
        default: begin mc = old % 2; mq = old / 2 + (sr ? HALF : 0); end
      endcase
      mo = (k == 4 && (top != (mq >= HALF))) ? 1 : 0;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R2: load, and load beating a simultaneous shift
    step(1, 8'hA5, 0, 0, 0, 0, "R2 load");
    step(1, 8'h3C, 2, 1, 0, 0, "R2 load over shift");
    // R3: idle
    step(0, 8'hFF, 0, 0, 1, 1, "R3 idle");
    step(0, 8'h00, 4, 0, 1, 1, "R3 idle");

    // R4 with R10
    step(1, 8'h81, 0, 0, 0, 0, "R4 setup");
    step(0, 0, 0, 1, 1, 1, "R4 LSL");
    step(0, 0, 1, 1, 1, 1, "R4 LSR");
    step(0, 0, 1, 1, 1, 1, "R4 LSR R10");

    // R5: rotate, full circle
    step(1, 8'h96, 0, 0, 0, 0, "R5 setup");
    for (int i = 0; i < W; i++) step(0, 0, 2, 1, 0, 0, "R5 ROL");
    for (int i = 0; i < 3; i++) step(0, 0, 3, 1, 0, 0, "R5 ROR R10");

    // R6: arithmetic right of a negative word
    step(1, 8'h90, 0, 0, 0, 0, "R6 setup");
    for (int i = 0; i < 5; i++) step(0, 0, 5, 1, 0, 0, "R6 ASR");

    // R7: no overflow, then 0->1 and 1->0 sign reversal
    step(1, 8'h21, 0, 0, 0, 0, "R7 setup");
    step(0, 0, 4, 1, 1, 1, "R7 ASL no ovf");
    step(0, 0, 4, 1, 1, 1, "R7 ASL ovf 0->1");
    step(1, 8'hBF, 0, 0, 0, 0, "R7 setup");
    step(0, 0, 4, 1, 0, 0, "R7 ASL ovf 1->0");
    // R8: other shift clears overflow
    step(0, 0, 1, 1, 0, 0, "R8 LSR clears ovf");
    step(1, 8'h40, 0, 0, 0, 0, "R8 setup");
    step(0, 0, 4, 1, 0, 0, "R8 ASL sets ovf");
    step(1, 8'h40, 0, 0, 0, 0, "R2 load clears ovf");

    // R9: serial fill
    step(1, 8'h00, 0, 0, 0, 0, "R9 setup");
    step(0, 0, 6, 1, 1, 0, "R9 SSL 1");
    step(0, 0, 6, 1, 0, 1, "R9 SSL 0");
    step(0, 0, 6, 1, 1, 0, "R9 SSL 1");
    step(0, 0, 7, 1, 0, 1, "R9 SSR 1");
    step(0, 0, 7, 1, 1, 0, "R9 SSR 0");

    // R10: mixed random traffic
    for (int i = 0; i < 300; i++) begin
      step(($urandom % 8) == 0, int'($urandom % MOD), int'($urandom % 8),
           ($urandom % 4) != 0, 1'($urandom), 1'($urandom), "R10 mixed");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule